// File: doc/BRIEF.md
# Flash Write-Protection Arbiter

This block rules on every program or erase request that a boot-block flash controller model issues. It looks at the request's target block and operation type. It also looks at the levels of the write-protect pin and the reset/power-down pin, at a digitised code for the programming supply, at the boot orientation and at the array density. From these it answers with a single-cycle grant or a single-cycle reject. Each reject ORs error flags into a sticky status byte, and a clear strobe empties that byte.

Only two small parameter blocks can be locked in hardware. Which two depends on the orientation and the density. With the boot region at the top, the pair is the two highest-numbered blocks of the array. With the boot region at the bottom, the pair is blocks 0 and 1. Three conditions override the write-protect decision and lock every block: a power-down pin held low, a supply that has fallen below lockout, and a supply at a level that is not valid for writing. Releasing power-down never releases the write-protect lock.

Top module: `flash_wprot_arbiter`

## Requirements
- R1: After reset, grant and reject are low and all eight status bits are 0.
- R2: A request sampled at a rising edge with req_valid high produces, at the next rising edge, exactly one of grant or reject high for exactly one cycle. With no request, neither output pulses.
- R3: The density code sets the block count: 0 gives 15 blocks, 1 gives 23, 2 gives 39 and 3 gives 71. With top_boot=1 the lockable pair is the two highest blocks (count-2 and count-1). With top_boot=0 the lockable pair is blocks 0 and 1.
- R4: If the request is not rejected for a higher-priority reason, a request to a lockable block with wp_level=0 is rejected and sets status bit 1 plus the operation bit. With wp_level=1 the same request is granted. A request to a non-lockable in-range block is granted whatever the wp_level.
- R5: With pd_level=0, every request is rejected and sets status bit 1 plus the operation bit, whatever the supply code and wp_level. Driving pd_level=1 does not release a lock that wp_level=0 imposes.
- R6: Supply code 2'b00 (below lockout) or 2'b11 (invalid level) rejects any request and sets status bit 3 plus the operation bit. Codes 2'b01 and 2'b10 permit writes.
- R7: A request to a block number at or above the block count is rejected and sets only the operation bit.
- R8: The operation bit is status bit 4 for a program (req_erase=0) and status bit 5 for an erase (req_erase=1). No other status bit is ever set.
- R9: Status bits stay set until clr_status is sampled high, and that clears them. Bits set by a reject decided at the same edge as a clear survive the clear.
- R10: When several reject causes apply at once, only the highest-priority one is reported. The order, from highest, is power-down, then supply, then range, then lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_block | input | 7 | Target block number |
| wp_level | input | 1 | Write-protect pin level (0 locks the pair) |
| pd_level | input | 1 | Reset/power-down pin level (0 locks everything) |
| vpp_code | input | 2 | Digitised programming-supply class |
| top_boot | input | 1 | 1 = boot blocks at the top of the array |
| density | input | 2 | Array size selector |
| clr_status | input | 1 | Clears the sticky status bits |
| grant | output | 1 | One-cycle grant pulse |
| reject | output | 1 | One-cycle reject pulse |
| status | output | 8 | Sticky error bits |

## Verification
The bench sweeps every density, both orientations, block numbers just past the largest array, both pin levels and all four supply codes for both operations, and compares each answer with a value it computes itself. It checks the top-orientation pair at each density. A design that took a fixed pair, or that was off by one at the block count, would grant a locked block or reject a legal one. It checks that power-down and supply errors win over range and lock errors, because a wrong priority order would report the wrong status bit. It also checks that bits accumulate across rejects without a clear, and that a reject decided at the same edge as a clear keeps its bits. A design that cleared after setting would lose that error.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam int BLK_W     = 7;
    localparam int ST_W      = 8;
    localparam int ST_LOCK   = 1;
    localparam int ST_SUPPLY = 3;
    localparam int ST_PROG   = 4;
    localparam int ST_ERASE  = 5;
    localparam int PARAM_BLKS = 8;

    typedef enum logic [1:0] {
        VPP_LOCKOUT = 2'b00,
        VPP_LOW     = 2'b01,
        VPP_HIGH    = 2'b10,
        VPP_BAD     = 2'b11
    } vpp_code_e;

    typedef enum logic [1:0] {
        DEN_4M  = 2'd0,
        DEN_8M  = 2'd1,
        DEN_16M = 2'd2,
        DEN_32M = 2'd3
    } density_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef enum logic [2:0] {
        V_GRANT  = 3'd0,
        V_PWRDN  = 3'd1,
        V_SUPPLY = 3'd2,
        V_RANGE  = 3'd3,
        V_LOCKED = 3'd4
    } verdict_e;

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [BLK_W-1:0] blk;
        logic             wp_hi;
        logic             pd_hi;
        vpp_code_e        vpp;
        logic             top_boot;
        density_e         den;
    } req_t;

    // Parameter blocks plus main blocks, where the main-block count doubles per density step.
    function automatic logic [BLK_W:0] block_count(density_e d);
        int n;
        n = (PARAM_BLKS - 1) + (PARAM_BLKS << int'(d));
        return (BLK_W+1)'(n);
    endfunction

    function automatic logic vpp_writable(vpp_code_e v);
        return (v == VPP_LOW) || (v == VPP_HIGH);
    endfunction

endpackage

// File: rtl/fp_block_map.sv
module fp_block_map
    import flash_prot_pkg::*;
(
    input  logic             top_boot,
    input  density_e         den,
    input  logic [BLK_W-1:0] blk,
    output logic             in_range,
    output logic             lockable
);
    localparam logic [BLK_W:0] ONE = (BLK_W+1)'(1);
    localparam logic [BLK_W:0] TWO = (BLK_W+1)'(2);

    logic [BLK_W:0] cnt;
    logic [BLK_W:0] blk_x;

    always_comb begin
        cnt      = block_count(den);
        blk_x    = {1'b0, blk};
        in_range = blk_x < cnt;
        if (top_boot)
            lockable = (blk_x == cnt - ONE) || (blk_x == cnt - TWO);
        else
            lockable = blk_x < TWO;
    end
endmodule

// File: rtl/fp_verdict.sv
module fp_verdict
    import flash_prot_pkg::*;
(
    input  req_t            rq,
    input  logic            in_range,
    input  logic            lockable,
    output verdict_e        verdict,
    output logic [ST_W-1:0] err_bits
);
    always_comb begin
        verdict  = V_GRANT;
        err_bits = '0;
        if (!rq.pd_hi) begin
            verdict           = V_PWRDN;
            err_bits[ST_LOCK] = 1'b1;
        end else if (!vpp_writable(rq.vpp)) begin
            verdict             = V_SUPPLY;
            err_bits[ST_SUPPLY] = 1'b1;
        end else if (!in_range) begin
            verdict = V_RANGE;
        end else if (lockable && !rq.wp_hi) begin
            verdict           = V_LOCKED;
            err_bits[ST_LOCK] = 1'b1;
        end
        if (verdict != V_GRANT) begin
            if (rq.op == OP_ERASE) err_bits[ST_ERASE] = 1'b1;
            else                   err_bits[ST_PROG]  = 1'b1;
        end
    end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
    import flash_prot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            set_en,
    input  logic [ST_W-1:0] set_bits,
    output logic [ST_W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (clr ? '0 : status) | (set_en ? set_bits : '0);
    end

    // R9: without a clear, no set bit is ever lost
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status & $past(status)) == $past(status)));

    // R8: only the four defined error positions can ever be set
    p_defined_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (status & ~(ST_W'(1) << ST_LOCK | ST_W'(1) << ST_SUPPLY |
                    ST_W'(1) << ST_PROG | ST_W'(1) << ST_ERASE)) == '0);
endmodule

// File: rtl/flash_wprot_arbiter.sv
module flash_wprot_arbiter
    import flash_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_erase,
    input  logic [BLK_W-1:0] req_block,
    input  logic             wp_level,
    input  logic             pd_level,
    input  logic [1:0]       vpp_code,
    input  logic             top_boot,
    input  logic [1:0]       density,
    input  logic             clr_status,
    output logic             grant,
    output logic             reject,
    output logic [ST_W-1:0]  status
);
    req_t            rs;
    logic            in_range;
    logic            lockable;
    verdict_e        verdict;
    logic [ST_W-1:0] err_bits;

    // Request register: every input that matters is captured together.
    always_ff @(posedge clk) begin
        if (rst) begin
            rs <= '0;
        end else begin
            rs.valid    <= req_valid;
            rs.op       <= req_erase ? OP_ERASE : OP_PROGRAM;
            rs.blk      <= req_block;
            rs.wp_hi    <= wp_level;
            rs.pd_hi    <= pd_level;
            rs.vpp      <= vpp_code_e'(vpp_code);
            rs.top_boot <= top_boot;
            rs.den      <= density_e'(density);
        end
    end

    fp_block_map u_map (
        .top_boot (rs.top_boot),
        .den      (rs.den),
        .blk      (rs.blk),
        .in_range (in_range),
        .lockable (lockable)
    );

    fp_verdict u_verdict (
        .rq       (rs),
        .in_range (in_range),
        .lockable (lockable),
        .verdict  (verdict),
        .err_bits (err_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= rs.valid && (verdict == V_GRANT);
            reject <= rs.valid && (verdict != V_GRANT);
        end
    end

    fp_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_status),
        .set_en   (rs.valid),
        .set_bits (err_bits),
        .status   (status)
    );

    // R2: never both answers at once
    p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    // R2: a registered request is always answered on the next edge
    p_answered_r2: assert property (@(posedge clk) disable iff (rst)
        rs.valid |=> (grant || reject));

    // R2: no answer without a registered request
    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rs.valid |=> (!grant && !reject));

    // R5: power-down low rejects and flags the lock bit
    p_pwrdn_r5: assert property (@(posedge clk) disable iff (rst)
        (rs.valid && !rs.pd_hi) |=> (reject && status[ST_LOCK]));

    // R6: an unusable supply rejects and flags the supply bit
    p_supply_r6: assert property (@(posedge clk) disable iff (rst)
        (rs.valid && rs.pd_hi && (rs.vpp == VPP_LOCKOUT || rs.vpp == VPP_BAD))
        |=> (reject && status[ST_SUPPLY]));

    // R4: the protected pair is never granted while write-protect is low
    p_wp_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (rs.valid && lockable && !rs.wp_hi) |=> !grant);
endmodule

// File: tb/tb_flash_wprot_arbiter.sv
module tb_flash_wprot_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_erase, wp_level, pd_level, top_boot, clr_status;
    logic [6:0] req_block;
    logic [1:0] vpp_code, density;
    logic       grant, reject;
    logic [7:0] status;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_wprot_arbiter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
        .req_block(req_block), .wp_level(wp_level), .pd_level(pd_level),
        .vpp_code(vpp_code), .top_boot(top_boot), .density(density),
        .clr_status(clr_status), .grant(grant), .reject(reject), .status(status)
    );

    task automatic check(input bit ok, input string rq, input logic [9:0] act,
                         input logic [9:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Computes the expected answer from the requirement text.
    task automatic model(input int d, input bit tb, input int blk, input bit er,
                         input bit wp, input bit pd, input int vc,
                         output bit g, output logic [7:0] st, output string tag);
        int  cnt;
        bit  lk;
        logic [7:0] opb;
        cnt = 7 + (8 << d);                          // R3 counts 15/23/39/71
        lk  = tb ? (blk == cnt - 1 || blk == cnt - 2) : (blk < 2);
        opb = er ? 8'h20 : 8'h10;                    // R8
        g = 1'b0;
        if (!pd)                       begin st = 8'h02 | opb; tag = "R5/R10"; end
        else if (vc == 0 || vc == 3)   begin st = 8'h08 | opb; tag = "R6/R10"; end
        else if (blk >= cnt)           begin st = opb;         tag = "R7/R10"; end
        else if (lk && !wp)            begin st = 8'h02 | opb; tag = "R4/R3";  end
        else begin g = 1'b1; st = 8'h00; tag = lk ? "R4/R3" : "R4"; end
    endtask

    task automatic issue(input int d, input bit tb, input int blk, input bit er,
                         input bit wp, input bit pd, input int vc, input bit clr_at_answer);
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_block = 7'(blk); wp_level = wp;
        pd_level = pd; vpp_code = 2'(vc); top_boot = tb; density = 2'(d);
        @(negedge clk);
        req_valid = 1'b0;
        clr_status = clr_at_answer;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        bit g;
        logic [7:0] st;
        string tag;
        rst = 1'b1; req_valid = 0; req_erase = 0; req_block = 0; wp_level = 1;
        pd_level = 1; vpp_code = 2'b01; top_boot = 0; density = 0; clr_status = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!grant && !reject && status == 8'h00, "R1 reset",
              {grant, reject, status}, 10'h000);
        // R2 no pulse while idle
        repeat (3) @(negedge clk);
        check(!grant && !reject, "R2 idle", {grant, reject, status}, 10'h000);

        // Full sweep
        for (int d = 0; d < 4; d++)
          for (int tb = 0; tb < 2; tb++)
            for (int blk = 0; blk < 74; blk++)
              for (int pd = 0; pd < 2; pd++)
                for (int wp = 0; wp < 2; wp++)
                  for (int vc = 0; vc < 4; vc++)
                    for (int er = 0; er < 2; er++) begin
                        model(d, tb[0], blk, er[0], wp[0], pd[0], vc, g, st, tag);
                        issue(d, tb[0], blk, er[0], wp[0], pd[0], vc, 1'b0);
                        check(grant == g && reject == !g && status == st,
                              {tag, " R2 answer"}, {grant, reject, status},
                              {g, !g, st});
                        @(negedge clk);
                        check(!grant && !reject, "R2 single-cycle pulse",
                              {grant, reject, status}, {2'b00, st});
                        clr_status = 1'b1;
                        @(negedge clk);
                        clr_status = 1'b0;
                        check(status == 8'h00, "R9 clear", {2'b00, status}, 10'h000);
                    end

        // R9 sticky accumulation: supply reject on a program, then lock reject on an erase
        issue(2, 1'b0, 5, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        issue(2, 1'b0, 1, 1'b1, 1'b0, 1'b1, 1, 1'b0);
        check(status == 8'h3A, "R9 sticky accumulate", {2'b00, status}, 10'h03A);
        issue(2, 1'b0, 10, 1'b0, 1'b1, 1'b1, 2, 1'b0);   // a grant leaves the bits alone
        check(grant && status == 8'h3A, "R9 grant keeps bits",
              {grant, reject, status}, 10'h23A);
        // R9 clear at the same edge as a new reject: the new bits survive
        issue(0, 1'b1, 14, 1'b1, 1'b0, 1'b1, 2, 1'b1);
        check(reject && status == 8'h22, "R9 clear with same-edge reject",
              {grant, reject, status}, 10'h122);
        // R5 power-down high with write-protect low keeps the top pair at 32M locked
        issue(3, 1'b1, 70, 1'b0, 1'b0, 1'b1, 2, 1'b1);
        check(reject && status == 8'h12, "R5 power-down high does not unlock",
              {grant, reject, status}, 10'h112);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule